// File: doc/BRIEF.md
# SMBus Target Interface with Packet Error Checking

This block is the bus-side front end of a register-mapped device on a two-wire SMBus. It watches the open-drain clock and data lines. Both lines pass through a two-flop synchronizer and a glitch filter, and the block then recognises start, repeated-start and stop conditions. It answers to one fixed 7-bit address. The byte after the address is a command code, which the block presents to a register file. The block runs three kinds of transfer against that register file: write word, read word and block read.

The optional checksum is a CRC-8 with polynomial x^8+x^2+x+1 and a start value of zero. It covers every byte of the message, including each address byte. On a host write, the host may send the checksum after the high data byte. The block ACKs a checksum that matches its own running value, and only then strobes the write. A mismatch is NACKed and latches an error flag. A write that ends with a stop right after the high data byte commits without any check. On reads, the block sends the checksum once the host has ACKed the last data byte.

The data line is only ever pulled low, through an output enable. The register file sees a latched command code, a word index for block reads, a 16-bit write word with a one-cycle strobe, and a combinational 16-bit read word.

Top module: `smb_target_pec`

## Requirements
- R1: A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. A start that arrives directly after an acknowledged command byte is taken as a repeated start and keeps the command and the running checksum.
- R2: The first byte after a start is matched against address 7'b0001011 in bits 7..1, with bit 0 as the read flag (0 = write). Any other address gets no ACK, and the rest of the message causes no strobe.
- R3: A write word is address with bit 0 = 0, then the command, the low data byte and the high data byte, each ACKed and each shifted MSB first. A stop right after the high byte gives exactly one reg_wstb pulse. During that pulse reg_cmd holds the command and reg_wdata holds {high, low}.
- R4: The checksum is a CRC-8 (polynomial 0x07, start value 0) over all bytes of the message, address bytes included. A write checksum byte that matches this value is ACKed, and the write is strobed once.
- R5: A write checksum that does not match is NACKed, gives no strobe, and sets pec_err. pec_err is cleared when the next message addressed to this block matches its address. Messages to other addresses leave it unchanged.
- R6: A read word is a write-addressed command, a repeated start, then the address with bit 0 = 1. The block returns the low byte and then the high byte of reg_rdata, with reg_widx = 0. A read address that is not preceded by a command in the same message is NACKed.
- R7: When the host ACKs the last data byte of a read, the block sends the checksum byte, computed over the address, the command, the read address and all returned bytes.
- R8: When the host NACKs any byte the block sends, the block releases the data line for the rest of that message.
- R9: A command code of BLK_CMD_MIN (0x20) or above selects block read. The first byte returned is blk_len. Data byte k comes from word reg_widx = k/2, low byte for even k and high byte for odd k. After the last data byte comes the checksum, and a zero blk_len sends the checksum straight after the count.
- R10: sda_oe changes only while the filtered clock is low, and it is low after every stop.
- R11: A pulse on either line that is shorter than FILT_LEN clock cycles is ignored and does not disturb a transfer.
- R12: After reset, sda_oe, reg_wstb and pec_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_cmd | output | 8 | Latched command code |
| reg_widx | output | IDX_W | Word index during a block read, 0 otherwise |
| reg_rdata | input | 16 | Read word for reg_cmd and reg_widx |
| blk_len | input | 8 | Byte count returned by a block read |
| reg_wdata | output | 16 | Write word {high, low} |
| reg_wstb | output | 1 | One-cycle write strobe |
| pec_err | output | 1 | Sticky checksum mismatch flag |

## Verification
A line change reaches the protocol logic after the two synchronizer flops and FILT_LEN filter samples, plus one edge register, which is about six cycles with the defaults. Every block output follows one register later. The bench holds each line for twelve cycles between changes and samples the data line in the middle of the clock-high phase, well after the block has updated it on the preceding clock fall. Strobes are recorded by a monitor on the falling clock edge as soon as they occur. The count, command and data are compared a quarter bit after the stop or checksum byte that commits them, and the error flag is read only after the following stop.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    localparam logic [6:0] SMB_DEV_ADDR = 7'b0001011;
    localparam logic [7:0] CRC_POLY     = 8'h07;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WLO,
        PH_WHI,
        PH_WPEC,
        PH_WDONE,
        PH_RD,
        PH_RDONE
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] c;
        c = acc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/smb_glitch_filt.sv
module smb_glitch_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            run  <= '0;
            dout <= 1'b1;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 != dout) begin
                if (run == CW'(FILT_LEN - 1)) begin
                    dout <= s2;
                    run  <= '0;
                end else begin
                    run <= run + CW'(1);
                end
            end else begin
                run <= '0;
            end
        end
    end

    // R11: the filtered level only ever moves to a level the synchronizer held
    p_filt_follows_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> (dout == $past(s2)));

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events
    import smb_tgt_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl
);
    localparam int NLINES = 2;
    localparam int LSCL   = 1;
    localparam int LSDA   = 0;

    logic [NLINES-1:0] raw, filt, prev;

    assign raw = {scl_i, sda_i};

    for (genvar li = 0; li < NLINES; li++) begin : g_line
        smb_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[li]),
            .dout (filt[li])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= filt;
    end

    always_comb begin
        ev.start = filt[LSCL] & prev[LSCL] & prev[LSDA] & ~filt[LSDA];
        ev.stop  = filt[LSCL] & prev[LSCL] & ~prev[LSDA] & filt[LSDA];
        ev.rise  = filt[LSCL] & ~prev[LSCL];
        ev.fall  = ~filt[LSCL] & prev[LSCL];
        ev.sda   = filt[LSDA];
    end

    assign scl_lvl = filt[LSCL];

endmodule

// File: rtl/smb_crc8_acc.sv
module smb_crc8_acc
    import smb_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= 8'h00;
        else if (upd)   crc <= crc8_step(crc, din);
    end
endmodule

// File: rtl/smb_target_pec.sv
module smb_target_pec
    import smb_tgt_pkg::*;
#(
    parameter int         FILT_LEN    = 3,
    parameter logic [7:0] BLK_CMD_MIN = 8'h20,
    parameter int         IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [7:0]       reg_cmd,
    output logic [IDX_W-1:0] reg_widx,
    input  logic [15:0]      reg_rdata,
    input  logic [7:0]       blk_len,
    output logic [15:0]      reg_wdata,
    output logic             reg_wstb,
    output logic             pec_err
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ACK_SLOT = 4'd8;

    bus_ev_t    ev;
    logic       scl_lvl;
    phase_t     phase;
    logic [3:0] cnt;
    logic [7:0] sreg, txsh, wlo, txi, txi_m1, crc_q, crc_din, tx_byte, rx_byte;
    logic [15:0] wbuf;
    logic       dir_tx, ack_dec, cmd_valid, is_blk, tx_is_pec, wpend;
    logic       restart_ok, crc_clr, crc_upd, tx_pec, rx_phase;

    smb_bus_events #(.FILT_LEN(FILT_LEN)) u_ev (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (ev),
        .scl_lvl (scl_lvl)
    );

    smb_crc8_acc u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .upd (crc_upd),
        .din (crc_din),
        .crc (crc_q)
    );

    assign rx_byte    = {sreg[6:0], ev.sda};
    assign txi_m1     = txi - 8'd1;
    assign restart_ok = (phase == PH_WLO) && cmd_valid;
    assign rx_phase   = (phase == PH_ADDR) || (phase == PH_CMD) ||
                        (phase == PH_WLO)  || (phase == PH_WHI);

    // byte the target sends next, chosen by transfer kind and position
    always_comb begin
        tx_byte  = crc_q;
        tx_pec   = 1'b1;
        reg_widx = '0;
        if (txi == 8'd0) begin
            tx_byte = is_blk ? blk_len : reg_rdata[7:0];
            tx_pec  = 1'b0;
        end else if (!is_blk) begin
            if (txi == 8'd1) begin
                tx_byte = reg_rdata[15:8];
                tx_pec  = 1'b0;
            end
        end else begin
            reg_widx = txi_m1[IDX_W:1];
            if (txi_m1 < blk_len) begin
                tx_byte = txi_m1[0] ? reg_rdata[15:8] : reg_rdata[7:0];
                tx_pec  = 1'b0;
            end
        end
    end

    always_comb begin
        crc_clr = ev.start && !restart_ok;
        crc_upd = 1'b0;
        crc_din = rx_byte;
        if (!ev.start && !ev.stop) begin
            if (ev.rise && cnt == LAST_BIT && !dir_tx && rx_phase) begin
                crc_upd = 1'b1;
            end else if (ev.fall && cnt == 4'd0 && phase == PH_RD && !tx_pec) begin
                crc_upd = 1'b1;
                crc_din = tx_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            sreg      <= '0;
            txsh      <= '0;
            wlo       <= '0;
            wbuf      <= '0;
            txi       <= '0;
            dir_tx    <= 1'b0;
            ack_dec   <= 1'b0;
            cmd_valid <= 1'b0;
            is_blk    <= 1'b0;
            tx_is_pec <= 1'b0;
            wpend     <= 1'b0;
            sda_oe    <= 1'b0;
            reg_cmd   <= '0;
            reg_wdata <= '0;
            reg_wstb  <= 1'b0;
            pec_err   <= 1'b0;
        end else begin
            reg_wstb <= 1'b0;
            if (ev.stop) begin
                if (wpend) begin
                    reg_wstb  <= 1'b1;
                    reg_wdata <= wbuf;
                end
                wpend     <= 1'b0;
                phase     <= PH_IDLE;
                cmd_valid <= 1'b0;
                dir_tx    <= 1'b0;
                sda_oe    <= 1'b0;
                cnt       <= '0;
            end else if (ev.start) begin
                cnt    <= '0;
                dir_tx <= 1'b0;
                sda_oe <= 1'b0;
                wpend  <= 1'b0;
                phase  <= PH_ADDR;
                if (!restart_ok) cmd_valid <= 1'b0;
            end else if (ev.rise) begin
                if (cnt == ACK_SLOT) begin
                    cnt <= '0;
                    if (dir_tx && phase == PH_RD) begin
                        if (ev.sda || tx_is_pec) phase <= PH_RDONE;
                        else                     txi   <= txi + 8'd1;
                    end
                end else begin
                    cnt  <= cnt + 4'd1;
                    sreg <= rx_byte;
                    if (cnt == LAST_BIT && !dir_tx) begin
                        ack_dec <= 1'b0;
                        case (phase)
                            PH_ADDR: begin
                                if (rx_byte[7:1] != SMB_DEV_ADDR) begin
                                    phase <= PH_IDLE;
                                end else begin
                                    pec_err <= 1'b0;
                                    if (!rx_byte[0]) begin
                                        ack_dec <= 1'b1;
                                        phase   <= PH_CMD;
                                    end else if (cmd_valid) begin
                                        ack_dec <= 1'b1;
                                        phase   <= PH_RD;
                                        txi     <= '0;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                            end
                            PH_CMD: begin
                                reg_cmd   <= rx_byte;
                                is_blk    <= (rx_byte >= BLK_CMD_MIN);
                                cmd_valid <= 1'b1;
                                ack_dec   <= 1'b1;
                                phase     <= PH_WLO;
                            end
                            PH_WLO: begin
                                wlo     <= rx_byte;
                                ack_dec <= 1'b1;
                                phase   <= PH_WHI;
                            end
                            PH_WHI: begin
                                wbuf    <= {rx_byte, wlo};
                                wpend   <= 1'b1;
                                ack_dec <= 1'b1;
                                phase   <= PH_WPEC;
                            end
                            PH_WPEC: begin
                                wpend <= 1'b0;
                                if (rx_byte == crc_q) begin
                                    ack_dec   <= 1'b1;
                                    reg_wstb  <= 1'b1;
                                    reg_wdata <= wbuf;
                                    phase     <= PH_WDONE;
                                end else begin
                                    pec_err <= 1'b1;
                                    phase   <= PH_IDLE;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            end else if (ev.fall) begin
                if (cnt == ACK_SLOT) begin
                    sda_oe <= dir_tx ? 1'b0 : ack_dec;
                end else if (cnt == 4'd0) begin
                    if (phase == PH_RD) begin
                        dir_tx    <= 1'b1;
                        txsh      <= tx_byte;
                        tx_is_pec <= tx_pec;
                        sda_oe    <= ~tx_byte[7];
                    end else begin
                        dir_tx <= 1'b0;
                        sda_oe <= 1'b0;
                    end
                end else begin
                    sda_oe <= dir_tx & ~txsh[3'd7 - cnt[2:0]];
                end
            end
        end
    end

    // R10: the data line is switched only while the clock is low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);

    // R3: a write produces a single-cycle strobe
    p_wstb_single_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wstb |=> !reg_wstb);

    // R3: a strobe leaves the message either finished or closed by a checksum
    p_wstb_state_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wstb |-> (phase == PH_WDONE || phase == PH_IDLE));

    // R5: a checksum mismatch never commits the write
    p_bad_pec_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pec_err) |-> !reg_wstb);

    // R8: after the host refuses a byte the line is released at the next clock fall
    p_release_after_nack_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RDONE && ev.fall && cnt == 4'd0) |=> !sda_oe);

endmodule

// File: tb/test_smb_target_pec.sv
module test_smb_target_pec;

    localparam int Q = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic        g = 1'b0;
    logic        sda_line;
    logic        sda_oe;
    logic [7:0]  reg_cmd;
    logic [3:0]  reg_widx;
    logic [15:0] reg_rdata;
    logic [7:0]  blk_len = 8'd5;
    logic [15:0] reg_wdata;
    logic        reg_wstb;
    logic        pec_err;

    int checks = 0;
    int fails  = 0;
    int wcount = 0;
    logic [7:0]  wcmd = '0;
    logic [15:0] wdat = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe & ~g;

    function automatic logic [15:0] rd_model(input logic [7:0] c, input logic [3:0] i);
        logic [7:0] lo;
        lo = c + {3'b000, i, 1'b0};
        return {~lo, lo};
    endfunction

    function automatic logic [7:0] bcrc(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] c;
        c = acc ^ b;
        for (int i = 0; i < 8; i++) c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
        return c;
    endfunction

    assign reg_rdata = rd_model(reg_cmd, reg_widx);

    smb_target_pec i_smb_target_pec (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_h),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_cmd   (reg_cmd),
        .reg_widx  (reg_widx),
        .reg_rdata (reg_rdata),
        .blk_len   (blk_len),
        .reg_wdata (reg_wdata),
        .reg_wstb  (reg_wstb),
        .pec_err   (pec_err)
    );

    always @(negedge clk) begin
        if (reg_wstb) begin
            wcount <= wcount + 1;
            wcmd   <= reg_cmd;
            wdat   <= reg_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hbit(input logic b, input logic gl, output logic s);
        sda_h = b;
        wait_c(Q);
        scl_h = 1'b1;
        wait_c(Q / 2);
        if (gl && b) begin
            g = 1'b1;
            wait_c(1);
            g = 1'b0;
        end
        s = sda_h & ~sda_oe;
        wait_c(Q / 2);
        scl_h = 1'b0;
        wait_c(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, input logic gl, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) hbit(b[i], gl, s);
        hbit(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hbit(1'b1, 1'b0, s);
            b = {b[6:0], s};
        end
        hbit(~give_ack, 1'b0, s);
    endtask

    task automatic bstart();
        sda_h = 1'b0; wait_c(Q);
        scl_h = 1'b0; wait_c(Q);
    endtask

    task automatic brestart();
        sda_h = 1'b1; wait_c(Q);
        scl_h = 1'b1; wait_c(Q);
        sda_h = 1'b0; wait_c(Q);
        scl_h = 1'b0; wait_c(Q);
    endtask

    task automatic bstop();
        sda_h = 1'b0; wait_c(Q);
        scl_h = 1'b1; wait_c(Q);
        sda_h = 1'b1; wait_c(Q);
    endtask

    // {addr7, cmd, data16, use_pec, bad_pec, glitch}
    localparam int NV = 6;
    localparam logic [33:0] WV [NV] = '{
        {7'h0B, 8'h10, 16'h1234, 1'b0, 1'b0, 1'b0},
        {7'h0B, 8'h3C, 16'hBEEF, 1'b1, 1'b0, 1'b1},
        {7'h0B, 8'h05, 16'h00FF, 1'b1, 1'b1, 1'b0},
        {7'h0C, 8'h10, 16'h5555, 1'b0, 1'b0, 1'b0},
        {7'h0B, 8'hFF, 16'h8001, 1'b0, 1'b0, 1'b0},
        {7'h0A, 8'h22, 16'hA5A5, 1'b1, 1'b0, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic        ack;
        logic [7:0]  b, c, pec;
        logic        err_exp;
        int          wbase;

        wait_c(5);
        rst = 1'b0;
        wait_c(2);
        chk(sda_oe == 1'b0,   "R12 sda_oe after reset",   32'(sda_oe),   0);
        chk(reg_wstb == 1'b0, "R12 reg_wstb after reset", 32'(reg_wstb), 0);
        chk(pec_err == 1'b0,  "R12 pec_err after reset",  32'(pec_err),  0);

        // table of write transfers
        err_exp = 1'b0;
        for (int v = 0; v < NV; v++) begin
            logic [6:0]  a;
            logic [7:0]  cm;
            logic [15:0] d;
            logic        up, bad, gl, match;
            a = WV[v][33:27]; cm = WV[v][26:19]; d = WV[v][18:3];
            up = WV[v][2]; bad = WV[v][1]; gl = WV[v][0];
            match = (a == 7'h0B);
            wbase = wcount;
            bstart();
            wbyte({a, 1'b0}, gl, ack);
            chk(ack == match, "R2 address acknowledge", 32'(ack), 32'(match));
            if (match) begin
                err_exp = up & bad;
                c = bcrc(8'h00, {a, 1'b0});
                c = bcrc(c, cm); c = bcrc(c, d[7:0]); c = bcrc(c, d[15:8]);
                wbyte(cm, gl, ack);      chk(ack, "R3 command ack", 32'(ack), 1);
                wbyte(d[7:0], gl, ack);  chk(ack, "R3 low byte ack", 32'(ack), 1);
                wbyte(d[15:8], gl, ack); chk(ack, "R3 high byte ack", 32'(ack), 1);
                if (up) begin
                    wbyte(bad ? (c ^ 8'h01) : c, gl, ack);
                    chk(ack == !bad, bad ? "R5 bad checksum NACK" : "R4 good checksum ACK", 32'(ack), 32'(!bad));
                end
            end
            bstop();
            wait_c(2);
            if (match && !(up && bad)) begin
                chk(wcount == wbase + 1, gl ? "R11 write with glitches strobes once" : "R1 R3 one strobe per write",
                    32'(wcount - wbase), 1);
                chk(wcmd == cm, "R3 strobe command", 32'(wcmd), 32'(cm));
                chk(wdat == d,  "R3 strobe data",    32'(wdat), 32'(d));
            end else begin
                chk(wcount == wbase, "R2 R5 no strobe", 32'(wcount - wbase), 0);
            end
            chk(pec_err == err_exp, "R5 error flag", 32'(pec_err), 32'(err_exp));
            chk(sda_oe == 1'b0, "R10 line released after stop", 32'(sda_oe), 0);
        end

        // read word with checksum
        bstart();
        wbyte(8'h16, 1'b0, ack); chk(ack, "R6 read addr write phase", 32'(ack), 1);
        wbyte(8'h11, 1'b0, ack); chk(ack, "R6 read command", 32'(ack), 1);
        brestart();
        wbyte(8'h17, 1'b0, ack); chk(ack, "R1 R6 repeated start read address", 32'(ack), 1);
        rbyte(1'b1, b); chk(b == 8'h11, "R6 read low byte", 32'(b), 32'h11);
        c = bcrc(bcrc(bcrc(bcrc(8'h00, 8'h16), 8'h11), 8'h17), 8'h11);
        rbyte(1'b1, b); chk(b == 8'hEE, "R6 read high byte", 32'(b), 32'hEE);
        c = bcrc(c, 8'hEE);
        rbyte(1'b0, pec); chk(pec == c, "R7 read word checksum", 32'(pec), 32'(c));
        bstop();

        // read word, host refuses the high byte
        bstart();
        wbyte(8'h16, 1'b0, ack);
        wbyte(8'h07, 1'b0, ack);
        brestart();
        wbyte(8'h17, 1'b0, ack);
        rbyte(1'b1, b); chk(b == 8'h07, "R6 second read low byte", 32'(b), 32'h07);
        rbyte(1'b0, b); chk(b == 8'hF8, "R6 second read high byte", 32'(b), 32'hF8);
        rbyte(1'b0, b); chk(b == 8'hFF, "R8 line released after NACK", 32'(b), 32'hFF);
        bstop();

        // read address without a command
        bstart();
        wbyte(8'h17, 1'b0, ack); chk(!ack, "R6 read without command NACKed", 32'(ack), 0);
        bstop();

        // block read, five bytes
        blk_len = 8'd5;
        bstart();
        wbyte(8'h16, 1'b0, ack);
        wbyte(8'h25, 1'b0, ack); chk(ack, "R9 block command ack", 32'(ack), 1);
        brestart();
        wbyte(8'h17, 1'b0, ack);
        c = bcrc(bcrc(bcrc(8'h00, 8'h16), 8'h25), 8'h17);
        rbyte(1'b1, b); chk(b == 8'd5, "R9 block count", 32'(b), 5);
        c = bcrc(c, b);
        for (int k = 0; k < 5; k++) begin
            logic [15:0] w;
            logic [7:0]  e;
            w = rd_model(8'h25, 4'(k / 2));
            e = (k % 2 == 1) ? w[15:8] : w[7:0];
            rbyte(1'b1, b);
            chk(b == e, "R9 block data byte", 32'(b), 32'(e));
            c = bcrc(c, e);
        end
        rbyte(1'b0, pec); chk(pec == c, "R7 R9 block checksum", 32'(pec), 32'(c));
        bstop();

        // block read with zero length
        blk_len = 8'd0;
        bstart();
        wbyte(8'h16, 1'b0, ack);
        wbyte(8'h20, 1'b0, ack);
        brestart();
        wbyte(8'h17, 1'b0, ack);
        rbyte(1'b1, b); chk(b == 8'd0, "R9 zero count", 32'(b), 0);
        c = bcrc(bcrc(bcrc(bcrc(8'h00, 8'h16), 8'h20), 8'h17), 8'h00);
        rbyte(1'b0, pec); chk(pec == c, "R9 checksum after zero count", 32'(pec), 32'(c));
        bstop();
        wait_c(4);
        chk(sda_oe == 1'b0, "R10 idle after reads", 32'(sda_oe), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule